// File: doc/BRIEF.md
# Command ring packet processor

This block is the consumer side of a command queue. A producer places 32-bit command words into a circular buffer in memory and advances a write pointer. The block reads words one at a time over a simple request/response memory port and decodes them as packets. Each packet starts with a header word, and its payload words follow.

A register packet turns its payload into a run of writes to consecutive register offsets on a valid/ready output port. An opcode packet sends its payload to a stream output, tagged with the opcode. A filler packet does nothing. The read pointer is exported so that the producer can see how far the ring has been consumed.

Two register offsets are special: the indirect-buffer base and the indirect-buffer size. A write of a nonzero size, once its packet ends, moves fetching to the indirect buffer. When that buffer is used up, fetching goes back to the ring at the next packet.

Top module: `cmdring_proc`

## Requirements
- R1: When `rptr` equals `wptr` and no indirect buffer is active, the block requests no memory word and, once the packet in flight is done, raises `idle`. After a packet is consumed, `rptr` points at the word after it.
- R2: `rptr` counts ring words modulo 2^`ring_lg`, and word k of the ring is read at address `ring_base + k`.
- R3: The packet kind is in header bits [31:30], and bits [29:16] hold the payload length minus one. Kind 0 writes payload word i to register offset (header bits [12:0]) + i, in order.
- R4: A kind 2 header is a single filler word. It produces no register write and no stream word.
- R5: A kind 3 packet puts each payload word on the stream output with `op_code` = header bits [7:0]. `op_last` is set only on the final payload word. It makes no register write.
- R6: A packet whose header and payload lie on both sides of the ring's wrap point is decoded the same as an unbroken one.
- R7: While `reg_valid` is high and `reg_ready` is low, `reg_addr` and `reg_data` hold their values. No payload word is lost or repeated.
- R8: A kind 0 write to offset 0x100 sets the indirect base, and a write to offset 0x101 sets the indirect size in words. Both are also forwarded on the register port. A nonzero size makes the block read that many words from the base address once the current packet ends.
- R9: While the indirect buffer is active, `rptr` does not move. When its last word has been consumed, decoding resumes in the ring at the word after the packet that started it.
- R10: A write to offset 0x100 or 0x101 decoded inside an indirect buffer is dropped from the register port, causes no diversion, and sets `err`.
- R11: A kind 1 header sets `err`. Once set, `err` stays set until reset. After a kind 1 header, all fetching stops, so `rptr` stays one word past that header and later packets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | ADDR_W | Word address of ring word 0 |
| ring_lg | input | LG_W | log2 of ring size in words |
| wptr | input | PTR_W | Producer write pointer |
| rptr | output | PTR_W | Consumer read pointer |
| mem_req | output | 1 | Word read request, one cycle |
| mem_addr | output | ADDR_W | Word address of the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| reg_valid | output | 1 | Register write valid |
| reg_addr | output | 13 | Register dword offset |
| reg_data | output | 32 | Register write data |
| reg_ready | input | 1 | Register port accepts |
| op_valid | output | 1 | Opcode stream word valid |
| op_code | output | 8 | Opcode of the packet |
| op_data | output | 32 | Payload word |
| op_last | output | 1 | Last payload word of packet |
| idle | output | 1 | Nothing to fetch and between packets |
| err | output | 1 | Sticky error flag |

## Verification
The hardest state to reach from the ports is the end of an indirect buffer: the last buffer word has to be consumed while ring words are still waiting behind the packet that started the diversion. The stimulus gets there by placing a base/size packet in the ring with a further register packet after it, and then checking the order of the writes. The nested case is reached by putting a size write inside the indirect buffer itself. Wraparound is reached by using an eight-word ring, first advancing the pointer with filler words, and then giving the write pointer a value below the read pointer so that one packet spans the wrap.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;

    localparam int WORD_W = 32;
    localparam int REGA_W = 13;
    localparam int CNT_W  = 14;
    localparam int OPC_W  = 8;

    typedef enum logic [1:0] {
        PK_REG  = 2'd0,
        PK_BAD  = 2'd1,
        PK_FILL = 2'd2,
        PK_OP   = 2'd3
    } pkt_kind_e;

    typedef struct packed {
        pkt_kind_e         kind;
        logic [CNT_W-1:0]  len_m1;
        logic [OPC_W-1:0]  opcode;
        logic [REGA_W-1:0] reg_off;
    } hdr_t;

    typedef enum logic [2:0] {
        DS_HDR,
        DS_PAY,
        DS_WR,
        DS_END,
        DS_HALT
    } dec_st_e;

    function automatic hdr_t split_hdr(input logic [WORD_W-1:0] w);
        hdr_t h;
        h.kind    = pkt_kind_e'(w[31:30]);
        h.len_m1  = w[29:16];
        h.opcode  = w[7:0];
        h.reg_off = w[12:0];
        return h;
    endfunction

endpackage

// File: rtl/cmdring_fetch.sv
module cmdring_fetch
    import cmdring_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PTR_W  = 12,
    parameter int LG_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [LG_W-1:0]   ring_lg,
    input  logic [PTR_W-1:0]  wptr,
    input  logic              want,
    input  logic              ib_start,
    input  logic [ADDR_W-1:0] ib_base,
    input  logic [ADDR_W-1:0] ib_size,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [PTR_W-1:0]  rptr,
    output logic              in_ib,
    output logic              busy,
    output logic              word_vld,
    output logic [WORD_W-1:0] word_data
);

    logic [ADDR_W-1:0] ib_ptr;
    logic [ADDR_W-1:0] ib_left;
    logic [PTR_W-1:0]  wrap_mask;
    logic              ring_avail;
    logic              ib_avail;
    logic              issue;

    assign wrap_mask  = ~({PTR_W{1'b1}} << ring_lg);
    assign ring_avail = (rptr != wptr);
    assign ib_avail   = (ib_left != '0);
    assign issue      = want && !busy && !ib_start && (in_ib ? ib_avail : ring_avail);

    assign mem_req   = issue;
    assign mem_addr  = in_ib ? ib_ptr : (ring_base + ADDR_W'(rptr));
    assign word_vld  = mem_rvalid && busy;
    assign word_data = mem_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            rptr    <= '0;
            in_ib   <= 1'b0;
            ib_ptr  <= '0;
            ib_left <= '0;
        end else begin
            if (issue)
                busy <= 1'b1;
            else if (mem_rvalid)
                busy <= 1'b0;

            if (ib_start) begin
                in_ib   <= 1'b1;
                ib_ptr  <= ib_base;
                ib_left <= ib_size;
            end else if (issue) begin
                if (in_ib) begin
                    ib_ptr  <= ib_ptr + 1'b1;
                    ib_left <= ib_left - 1'b1;
                end else begin
                    rptr <= (rptr + 1'b1) & wrap_mask;
                end
            end else if (in_ib && !ib_avail && !busy) begin
                in_ib <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cmdring_decode.sv
module cmdring_decode
    import cmdring_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter logic [REGA_W-1:0] IB_BASE_OFF = 13'h100,
    parameter logic [REGA_W-1:0] IB_SIZE_OFF = 13'h101
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word_data,
    input  logic              in_ib,
    output logic              want,
    output logic              at_hdr,
    output logic              ib_start,
    output logic [ADDR_W-1:0] ib_base,
    output logic [ADDR_W-1:0] ib_size,
    output logic              reg_valid,
    output logic [REGA_W-1:0] reg_addr,
    output logic [WORD_W-1:0] reg_data,
    input  logic              reg_ready,
    output logic              op_valid,
    output logic [OPC_W-1:0]  op_code,
    output logic [WORD_W-1:0] op_data,
    output logic              op_last,
    output logic              err
);

    dec_st_e           st;
    hdr_t              cur;
    pkt_kind_e         kind;
    logic [OPC_W-1:0]  opc;
    logic [REGA_W-1:0] off;
    logic [CNT_W:0]    left;
    logic              ib_pend;
    logic              is_ib_reg;
    logic              last_word;

    assign cur       = split_hdr(word_data);
    assign want      = (st == DS_HDR) || (st == DS_PAY);
    assign at_hdr    = (st == DS_HDR);
    assign is_ib_reg = (off == IB_BASE_OFF) || (off == IB_SIZE_OFF);
    assign last_word = (left == (CNT_W+1)'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= DS_HDR;
            kind      <= PK_FILL;
            opc       <= '0;
            off       <= '0;
            left      <= '0;
            ib_pend   <= 1'b0;
            ib_start  <= 1'b0;
            ib_base   <= '0;
            ib_size   <= '0;
            reg_valid <= 1'b0;
            reg_addr  <= '0;
            reg_data  <= '0;
            op_valid  <= 1'b0;
            op_code   <= '0;
            op_data   <= '0;
            op_last   <= 1'b0;
            err       <= 1'b0;
        end else begin
            op_valid <= 1'b0;
            ib_start <= 1'b0;
            case (st)
                DS_HDR: begin
                    if (word_vld) begin
                        kind <= cur.kind;
                        opc  <= cur.opcode;
                        off  <= cur.reg_off;
                        left <= {1'b0, cur.len_m1} + 1'b1;
                        case (cur.kind)
                            PK_REG, PK_OP: st <= DS_PAY;
                            PK_FILL:       st <= DS_HDR;
                            default: begin
                                err <= 1'b1;
                                st  <= DS_HALT;
                            end
                        endcase
                    end
                end
                DS_PAY: begin
                    if (word_vld) begin
                        if (kind == PK_OP) begin
                            op_valid <= 1'b1;
                            op_code  <= opc;
                            op_data  <= word_data;
                            op_last  <= last_word;
                            left     <= left - 1'b1;
                            if (last_word) st <= DS_END;
                        end else if (is_ib_reg && in_ib) begin
                            err  <= 1'b1;
                            off  <= off + 1'b1;
                            left <= left - 1'b1;
                            if (last_word) st <= DS_END;
                        end else begin
                            reg_valid <= 1'b1;
                            reg_addr  <= off;
                            reg_data  <= word_data;
                            st        <= DS_WR;
                        end
                    end
                end
                DS_WR: begin
                    if (reg_ready) begin
                        reg_valid <= 1'b0;
                        if (reg_addr == IB_BASE_OFF)
                            ib_base <= reg_data[ADDR_W-1:0];
                        if (reg_addr == IB_SIZE_OFF) begin
                            ib_size <= reg_data[ADDR_W-1:0];
                            ib_pend <= (reg_data[ADDR_W-1:0] != '0);
                        end
                        off  <= off + 1'b1;
                        left <= left - 1'b1;
                        st   <= last_word ? DS_END : DS_PAY;
                    end
                end
                DS_END: begin
                    if (ib_pend) begin
                        ib_start <= 1'b1;
                        ib_pend  <= 1'b0;
                    end
                    st <= DS_HDR;
                end
                default: st <= DS_HALT;
            endcase
        end
    end

endmodule

// File: rtl/cmdring_proc.sv
module cmdring_proc
    import cmdring_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter int                PTR_W       = 12,
    parameter int                LG_W        = 4,
    parameter logic [REGA_W-1:0] IB_BASE_OFF = 13'h100,
    parameter logic [REGA_W-1:0] IB_SIZE_OFF = 13'h101
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [LG_W-1:0]   ring_lg,
    input  logic [PTR_W-1:0]  wptr,
    output logic [PTR_W-1:0]  rptr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              reg_valid,
    output logic [REGA_W-1:0] reg_addr,
    output logic [WORD_W-1:0] reg_data,
    input  logic              reg_ready,
    output logic              op_valid,
    output logic [OPC_W-1:0]  op_code,
    output logic [WORD_W-1:0] op_data,
    output logic              op_last,
    output logic              idle,
    output logic              err
);

    logic              want;
    logic              at_hdr;
    logic              ib_start;
    logic [ADDR_W-1:0] ib_base;
    logic [ADDR_W-1:0] ib_size;
    logic              in_ib;
    logic              busy;
    logic              word_vld;
    logic [WORD_W-1:0] word_data;

    cmdring_fetch #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .LG_W(LG_W)) u_fetch (
        .clk(clk), .rst(rst),
        .ring_base(ring_base), .ring_lg(ring_lg), .wptr(wptr),
        .want(want), .ib_start(ib_start), .ib_base(ib_base), .ib_size(ib_size),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rptr(rptr), .in_ib(in_ib), .busy(busy),
        .word_vld(word_vld), .word_data(word_data)
    );

    cmdring_decode #(.ADDR_W(ADDR_W), .IB_BASE_OFF(IB_BASE_OFF), .IB_SIZE_OFF(IB_SIZE_OFF)) u_decode (
        .clk(clk), .rst(rst),
        .word_vld(word_vld), .word_data(word_data), .in_ib(in_ib),
        .want(want), .at_hdr(at_hdr),
        .ib_start(ib_start), .ib_base(ib_base), .ib_size(ib_size),
        .reg_valid(reg_valid), .reg_addr(reg_addr), .reg_data(reg_data), .reg_ready(reg_ready),
        .op_valid(op_valid), .op_code(op_code), .op_data(op_data), .op_last(op_last),
        .err(err)
    );

    assign idle = at_hdr && !in_ib && !busy && (rptr == wptr);

endmodule

// File: rtl/cmdring_proc_chk.sv
module cmdring_proc_chk #(
    parameter int PTR_W = 12,
    parameter int LG_W  = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [PTR_W-1:0] rptr,
    input logic [PTR_W-1:0] wptr,
    input logic [LG_W-1:0]  ring_lg,
    input logic             mem_req,
    input logic             in_ib,
    input logic             reg_valid,
    input logic             reg_ready,
    input logic [12:0]      reg_addr,
    input logic [31:0]      reg_data,
    input logic             err
);

    logic [PTR_W-1:0] msk;
    assign msk = ~({PTR_W{1'b1}} << ring_lg);

    // R1: an empty ring with no indirect buffer issues no read
    a_r1_no_fetch_empty: assert property (@(posedge clk) disable iff (rst)
        (!in_ib && (rptr == wptr)) |-> !mem_req);

    // R1: at most one read outstanding, so back-to-back requests never occur
    a_r1_single_req: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R2: the read pointer only ever steps by one modulo the ring size
    a_r2_ptr_step: assert property (@(posedge clk) disable iff (rst)
        (rptr != $past(rptr)) |-> (rptr == (($past(rptr) + 1'b1) & msk)));

    // R7: a stalled register write holds its address and data
    a_r7_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        (reg_valid && !reg_ready) |=> (reg_valid && $stable(reg_addr) && $stable(reg_data)));

    // R9: the ring pointer is frozen inside an indirect buffer
    a_r9_ring_frozen: assert property (@(posedge clk) disable iff (rst)
        (in_ib && $past(in_ib)) |-> $stable(rptr));

    // R11: the error flag is sticky
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

endmodule

bind cmdring_proc cmdring_proc_chk #(.PTR_W(PTR_W), .LG_W(LG_W)) u_chk (
    .clk(clk), .rst(rst), .rptr(rptr), .wptr(wptr), .ring_lg(ring_lg),
    .mem_req(mem_req), .in_ib(in_ib), .reg_valid(reg_valid), .reg_ready(reg_ready),
    .reg_addr(reg_addr), .reg_data(reg_data), .err(err)
);

// File: tb/cmdring_proc_bench.sv
`timescale 1ns/1ps
module cmdring_proc_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ring_base = '0;
    logic [3:0]  ring_lg = 4'd6;
    logic [11:0] wptr = '0;
    logic [11:0] rptr;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        reg_valid;
    logic [12:0] reg_addr;
    logic [31:0] reg_data;
    logic        reg_ready = 1'b1;
    logic        op_valid;
    logic [7:0]  op_code;
    logic [31:0] op_data;
    logic        op_last;
    logic        idle;
    logic        err;

    always #2 clk = ~clk;

    cmdring_proc u_cmdring_proc (
        .clk(clk), .rst(rst), .ring_base(ring_base), .ring_lg(ring_lg), .wptr(wptr),
        .rptr(rptr), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .reg_valid(reg_valid), .reg_addr(reg_addr), .reg_data(reg_data), .reg_ready(reg_ready),
        .op_valid(op_valid), .op_code(op_code), .op_data(op_data), .op_last(op_last),
        .idle(idle), .err(err)
    );

    logic [31:0] mem [0:1023];
    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    logic [12:0] wr_a [0:63];
    logic [31:0] wr_d [0:63];
    int          nwr = 0;
    logic [31:0] op_d [0:63];
    logic [7:0]  op_c [0:63];
    logic        op_l [0:63];
    int          nop = 0;
    logic        stall_mode = 1'b0;

    // memory responder and port monitors, all on the falling edge
    logic        rd_pend = 1'b0;
    int          rd_cnt = 0;
    logic [9:0]  rd_addr = '0;
    int          lat_seq = 0;

    always @(negedge clk) begin
        cyc++;
        if (mem_rvalid) mem_rvalid = 1'b0;
        if (rd_pend) begin
            rd_cnt--;
            if (rd_cnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem[rd_addr];
                rd_pend    = 1'b0;
            end
        end
        if (mem_req && !rst) begin
            rd_pend = 1'b1;
            rd_addr = mem_addr[9:0];
            rd_cnt  = 1 + (lat_seq % 3);
            lat_seq++;
        end
        reg_ready = stall_mode ? ((cyc % 3) == 0) : 1'b1;
        if (!rst && reg_valid && reg_ready && nwr < 64) begin
            wr_a[nwr] = reg_addr;
            wr_d[nwr] = reg_data;
            nwr++;
        end
        if (!rst && op_valid && nop < 64) begin
            op_d[nop] = op_data;
            op_c[nop] = op_code;
            op_l[nop] = op_last;
            nop++;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] hdr_reg(input int cnt, input logic [12:0] o);
        logic [13:0] l = 14'(cnt - 1);
        return {2'd0, l, 3'd0, o};
    endfunction

    function automatic logic [31:0] hdr_op(input int cnt, input logic [7:0] c);
        logic [13:0] l = 14'(cnt - 1);
        return {2'd3, l, 8'd0, c};
    endfunction

    localparam logic [31:0] HDR_FILL = 32'h8000_0000;
    localparam logic [31:0] HDR_BAD  = 32'h4000_0000;

    task automatic restart(input logic [3:0] lg, input logic [15:0] base);
        @(negedge clk);
        rst = 1'b1;
        ring_lg = lg;
        ring_base = base;
        wptr = '0;
        stall_mode = 1'b0;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        nwr = 0;
        nop = 0;
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_to(input logic [11:0] wp, input string tag);
        int t = 0;
        wptr = wp;
        repeat (4) @(negedge clk);
        while (!idle && t < 3000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 3000) begin
            n_chk++;
            n_fail++;
            $display("FAIL %s run timed out actual=busy expected=idle", tag);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 reset rptr", 32'(rptr), 0);
        check("R1 reset reg_valid", 32'(reg_valid), 0);
        check("R11 reset err", 32'(err), 0);
        check("R1 reset mem_req", 32'(mem_req), 0);
        restart(4'd6, 16'h0);
        repeat (3) @(negedge clk);
        check("R1 empty idle", 32'(idle), 1);
        check("R1 empty no request", 32'(mem_req), 0);
    endtask

    task automatic t_regwrite;
        restart(4'd6, 16'h0);
        mem[0] = hdr_reg(3, 13'h020);
        mem[1] = 32'hA000_0001;
        mem[2] = 32'hA000_0002;
        mem[3] = 32'hA000_0003;
        run_to(12'd4, "R3");
        check("R3 write count", nwr, 3);
        for (int i = 0; i < 3; i++) begin
            check("R3 write addr", 32'(wr_a[i]), 32'h20 + i);
            check("R3 write data", wr_d[i], 32'hA000_0001 + i);
        end
        check("R1 rptr after packet", 32'(rptr), 4);
        check("R1 idle after drain", 32'(idle), 1);
        check("R5 no stream from reg packet", nop, 0);
    endtask

    task automatic t_nop_opcode;
        restart(4'd6, 16'h0);
        mem[0] = HDR_FILL;
        mem[1] = hdr_op(2, 8'h5A);
        mem[2] = 32'hD000_0000;
        mem[3] = 32'hD000_0001;
        mem[4] = HDR_FILL;
        run_to(12'd5, "R5");
        check("R4 filler makes no writes", nwr, 0);
        check("R5 stream count", nop, 2);
        check("R5 stream word0", op_d[0], 32'hD000_0000);
        check("R5 stream word1", op_d[1], 32'hD000_0001);
        check("R5 opcode", 32'(op_c[1]), 32'h5A);
        check("R5 last flag first", 32'(op_l[0]), 0);
        check("R5 last flag final", 32'(op_l[1]), 1);
        check("R4 rptr past fillers", 32'(rptr), 5);
    endtask

    task automatic t_wrap;
        restart(4'd3, 16'h0040);
        for (int i = 0; i < 6; i++) mem[16'h40 + i] = HDR_FILL;
        run_to(12'd6, "R2");
        check("R2 rptr before wrap", 32'(rptr), 6);
        mem[16'h46] = hdr_reg(3, 13'h030);
        mem[16'h47] = 32'hB000_0007;
        mem[16'h40] = 32'hB000_0000;
        mem[16'h41] = 32'hB000_0001;
        run_to(12'd2, "R6");
        check("R2 rptr wrapped", 32'(rptr), 2);
        check("R6 straddle count", nwr, 3);
        check("R6 straddle word0", wr_d[0], 32'hB000_0007);
        check("R6 straddle word1", wr_d[1], 32'hB000_0000);
        check("R6 straddle word2 addr", 32'(wr_a[2]), 32'h32);
        check("R6 straddle word2", wr_d[2], 32'hB000_0001);
    endtask

    task automatic t_stall;
        restart(4'd6, 16'h0);
        stall_mode = 1'b1;
        mem[0] = hdr_reg(5, 13'h010);
        for (int i = 0; i < 5; i++) mem[1 + i] = 32'hC000_0000 + i;
        run_to(12'd6, "R7");
        check("R7 stalled write count", nwr, 5);
        for (int i = 0; i < 5; i++) begin
            check("R7 stalled addr", 32'(wr_a[i]), 32'h10 + i);
            check("R7 stalled data", wr_d[i], 32'hC000_0000 + i);
        end
    endtask

    task automatic t_indirect;
        restart(4'd6, 16'h0);
        mem[0] = hdr_reg(2, 13'h100);
        mem[1] = 32'h0000_0200;
        mem[2] = 32'h0000_0003;
        mem[3] = hdr_reg(1, 13'h050);
        mem[4] = 32'h0000_EEEE;
        mem[16'h200] = hdr_reg(2, 13'h060);
        mem[16'h201] = 32'hF000_0000;
        mem[16'h202] = 32'hF000_0001;
        run_to(12'd5, "R8");
        check("R8 write count", nwr, 5);
        check("R8 base forwarded", 32'(wr_a[0]), 32'h100);
        check("R8 size forwarded", wr_d[1], 32'h3);
        check("R8 indirect write addr", 32'(wr_a[2]), 32'h60);
        check("R8 indirect data0", wr_d[2], 32'hF000_0000);
        check("R8 indirect data1", wr_d[3], 32'hF000_0001);
        check("R9 ring resumes addr", 32'(wr_a[4]), 32'h50);
        check("R9 ring resumes data", wr_d[4], 32'h0000_EEEE);
        check("R9 rptr end", 32'(rptr), 5);
        check("R10 no error on legal entry", 32'(err), 0);
    endtask

    task automatic t_nested;
        restart(4'd6, 16'h0);
        mem[0] = hdr_reg(2, 13'h100);
        mem[1] = 32'h0000_0200;
        mem[2] = 32'h0000_0004;
        mem[3] = HDR_FILL;
        mem[16'h200] = hdr_reg(1, 13'h101);
        mem[16'h201] = 32'h0000_0009;
        mem[16'h202] = hdr_reg(1, 13'h070);
        mem[16'h203] = 32'h0000_0077;
        mem[16'h300] = hdr_reg(1, 13'h0EE);
        run_to(12'd4, "R10");
        check("R10 nested write dropped", nwr, 3);
        check("R10 following write addr", 32'(wr_a[2]), 32'h70);
        check("R10 following write data", wr_d[2], 32'h77);
        check("R10 error flag", 32'(err), 1);
        check("R10 ring resumed", 32'(rptr), 4);
    endtask

    task automatic t_illegal;
        restart(4'd6, 16'h0);
        mem[0] = hdr_reg(1, 13'h010);
        mem[1] = 32'h0000_0001;
        mem[2] = HDR_BAD;
        mem[3] = hdr_reg(1, 13'h011);
        mem[4] = 32'h0000_0002;
        wptr = 12'd5;
        repeat (60) @(negedge clk);
        check("R11 writes before halt", nwr, 1);
        check("R11 error set", 32'(err), 1);
        check("R11 rptr stopped", 32'(rptr), 3);
        check("R11 not idle when halted", 32'(idle), 0);
        repeat (60) @(negedge clk);
        check("R11 rptr still stopped", 32'(rptr), 3);
        check("R11 error sticky", 32'(err), 1);
    endtask

    initial begin
        t_reset();
        t_regwrite();
        t_nop_opcode();
        t_wrap();
        t_stall();
        t_indirect();
        t_nested();
        t_illegal();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule